// File: doc/BRIEF.md
# Read Window Edge Corrector

This block runs once, after reset, on the results of a single read-direction training run of one byte lane. For each of the lane's data bits it receives the first and the last passing delay tap, along with one lock flag per search direction. From these it forms the lane window: the latest of the bit starts and the earliest of the bit ends. It then decides whether that window is pushed against the bottom or the top of the delay range.

When the window sits on the low edge, every pad that some bit is routed to gets its read deskew raised by a fixed step, clamped at the field maximum. When the window sits on the high edge, the block raises two fixed pads by the same step and lets the sum wrap. The corrected values come out as a per-pad vector with a one-cycle write enable per pad, next to a done flag, a fail flag and the window size. Other logic performs the register write-back.

A start strobe triggers the evaluation, and the result appears on the next cycle. After the first evaluation the block stays disarmed, and any further start only answers with a quiet done. A re-arm input enables it again.

Top module: `rd_edge_corrector`

## Requirements
- R1: After reset, done_o, fail_o and every bit of pad_we_o are 0, win_size_o is 0, and the block is armed.
- R2: done_o is high for exactly the one cycle after each cycle in which start_i is high, and is low otherwise. fail_o and pad_we_o are only ever high together with done_o.
- R3: An armed start with lock_rise_i or lock_fall_i low gives done_o=1 and fail_o=1, win_size_o=0 and pad_we_o all 0. The start still uses up the armed state.
- R4: The lane start is the maximum of the eight bit_first_i fields (bit b at bits [5b+4:5b]), and the lane end is the minimum of the eight bit_last_i fields. On a locked armed start, win_size_o = end - start + 1, or 0 when end < start.
- R5: Low edge: when the lane start is at most 1, each pad that at least one bit maps to is written once with min(current + 10, 31). With the default map, bits 0..7 go to pads 0,1,2,3,4,0,1,2. A pad that no bit maps to (pad 5 by default) gets no low-edge write.
- R6: High edge: when the lane end is greater than 30, pad 4 and pad 5 are written with (value + 10) mod 32, with no saturation.
- R7: When both edges apply, the low-edge clamp is applied first and the wrapping high-edge step second, so pad 4 becomes (min(cur + 10, 31) + 10) mod 32.
- R8: A locked armed start with neither edge gives done_o=1, fail_o=0 and pad_we_o all 0.
- R9: A start while not armed gives done_o=1, fail_o=0, win_size_o=0 and pad_we_o all 0.
- R10: A pulse on rearm_i arms the block again. If rearm_i and start_i are high in the same cycle, that start is evaluated as an armed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Evaluation request strobe |
| rearm_i | input | 1 | Re-enables one more evaluation |
| lock_rise_i | input | 1 | Low-to-high search locked |
| lock_fall_i | input | 1 | High-to-low search locked |
| bit_first_i | input | 40 | Per-bit first passing tap, 5 bits per bit |
| bit_last_i | input | 40 | Per-bit last passing tap, 5 bits per bit |
| pad_cur_i | input | 30 | Current deskew per pad, 5 bits per pad |
| done_o | output | 1 | Result valid, one cycle |
| fail_o | output | 1 | Lock missing on an armed run |
| win_size_o | output | 6 | Lane window size |
| pad_val_o | output | 30 | Corrected deskew per pad |
| pad_we_o | output | 6 | Per-pad write enable, with done_o |

## Verification
The assertions assume that start_i and rearm_i are known after reset and that the tap, lock and deskew inputs are stable in any cycle where start_i is high. The bench changes inputs only on the falling clock edge and holds them through the start cycle. The assertions also assume that the deskew value fed back for the next run is taken from the bench, not from the outputs. Every scenario loads fresh deskew values, so pads that are not written can be told apart from pads that are written.

// File: rtl/rd_edge_pkg.sv
package rd_edge_pkg;

    typedef struct packed {
        logic low;
        logic high;
    } edge_flags_t;

    typedef enum logic [1:0] {
        RUN_NONE,
        RUN_SKIP,
        RUN_NOLOCK,
        RUN_EVAL
    } run_kind_t;

endpackage

// File: rtl/win_extent.sv
module win_extent #(
    parameter int NBITS = 8,
    parameter int TAP_W = 5
) (
    input  logic [NBITS-1:0][TAP_W-1:0] first_i,
    input  logic [NBITS-1:0][TAP_W-1:0] last_i,
    output logic [TAP_W-1:0]            lane_first_o,
    output logic [TAP_W-1:0]            lane_last_o
);

    logic [TAP_W-1:0] run_max [NBITS];
    logic [TAP_W-1:0] run_min [NBITS];

    assign run_max[0] = first_i[0];
    assign run_min[0] = last_i[0];

    for (genvar g = 1; g < NBITS; g++) begin : g_chain
        assign run_max[g] = (first_i[g] > run_max[g-1]) ? first_i[g] : run_max[g-1];
        assign run_min[g] = (last_i[g] < run_min[g-1]) ? last_i[g] : run_min[g-1];
    end

    assign lane_first_o = run_max[NBITS-1];
    assign lane_last_o  = run_min[NBITS-1];

endmodule

// File: rtl/edge_classify.sv
module edge_classify
    import rd_edge_pkg::*;
#(
    parameter int TAP_W      = 5,
    parameter int LOW_LIMIT  = 1,
    parameter int HIGH_LIMIT = 30
) (
    input  logic [TAP_W-1:0] lane_first_i,
    input  logic [TAP_W-1:0] lane_last_i,
    output edge_flags_t      flags_o,
    output logic [TAP_W:0]   size_o
);

    localparam logic [TAP_W-1:0] LOW_T  = TAP_W'(LOW_LIMIT);
    localparam logic [TAP_W-1:0] HIGH_T = TAP_W'(HIGH_LIMIT);

    always_comb begin
        flags_o.low  = (lane_first_i <= LOW_T);
        flags_o.high = (lane_last_i > HIGH_T);
        if (lane_last_i >= lane_first_i) begin
            size_o = {1'b0, lane_last_i} - {1'b0, lane_first_i} + {{TAP_W{1'b0}}, 1'b1};
        end else begin
            size_o = '0;
        end
    end

endmodule

// File: rtl/pad_fix.sv
module pad_fix
    import rd_edge_pkg::*;
#(
    parameter int          NBITS    = 8,
    parameter int          NPADS    = 6,
    parameter int          DSK_W    = 5,
    parameter int          STEP     = 10,
    parameter int          HI_PAD_A = 4,
    parameter int          HI_PAD_B = 5,
    parameter int unsigned BIT_PAD [NBITS] = '{0, 1, 2, 3, 4, 0, 1, 2}
) (
    input  logic [NPADS-1:0][DSK_W-1:0] cur_i,
    input  edge_flags_t                 flags_i,
    output logic [NPADS-1:0][DSK_W-1:0] val_o,
    output logic [NPADS-1:0]            touch_o
);

    localparam int                 SUM_W   = DSK_W + 8;
    localparam logic [SUM_W-1:0]   STEP_X  = SUM_W'(STEP);
    localparam logic [SUM_W-1:0]   DSK_MAX = SUM_W'((1 << DSK_W) - 1);
    localparam logic [DSK_W-1:0]   STEP_N  = DSK_W'(STEP);

    function automatic logic pad_hit(input int p);
        logic h;
        h = 1'b0;
        for (int b = 0; b < NBITS; b++) begin
            if (int'(BIT_PAD[b]) == p) h = 1'b1;
        end
        return h;
    endfunction

    for (genvar p = 0; p < NPADS; p++) begin : g_pad
        localparam logic HIT   = pad_hit(p);
        localparam logic HI_SEL = (p == HI_PAD_A) || (p == HI_PAD_B);

        logic [SUM_W-1:0] sum_w;
        logic [DSK_W-1:0] after_low;
        logic             low_on;
        logic             high_on;

        always_comb begin
            low_on  = HIT && flags_i.low;
            high_on = HI_SEL && flags_i.high;
            sum_w   = {{(SUM_W-DSK_W){1'b0}}, cur_i[p]} + STEP_X;
            if (!low_on) begin
                after_low = cur_i[p];
            end else if (sum_w > DSK_MAX) begin
                after_low = DSK_MAX[DSK_W-1:0];
            end else begin
                after_low = sum_w[DSK_W-1:0];
            end
            val_o[p]   = high_on ? (after_low + STEP_N) : after_low;
            touch_o[p] = low_on || high_on;
        end
    end

endmodule

// File: rtl/rd_edge_corrector.sv
module rd_edge_corrector
    import rd_edge_pkg::*;
#(
    parameter int          NBITS      = 8,
    parameter int          TAP_W      = 5,
    parameter int          NPADS      = 6,
    parameter int          DSK_W      = 5,
    parameter int          STEP       = 10,
    parameter int          LOW_LIMIT  = 1,
    parameter int          HIGH_LIMIT = 30,
    parameter int          HI_PAD_A   = 4,
    parameter int          HI_PAD_B   = 5,
    parameter int unsigned BIT_PAD [NBITS] = '{0, 1, 2, 3, 4, 0, 1, 2}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        rearm_i,
    input  logic                        lock_rise_i,
    input  logic                        lock_fall_i,
    input  logic [NBITS*TAP_W-1:0]      bit_first_i,
    input  logic [NBITS*TAP_W-1:0]      bit_last_i,
    input  logic [NPADS*DSK_W-1:0]      pad_cur_i,
    output logic                        done_o,
    output logic                        fail_o,
    output logic [TAP_W:0]              win_size_o,
    output logic [NPADS*DSK_W-1:0]      pad_val_o,
    output logic [NPADS-1:0]            pad_we_o
);

    typedef struct packed {
        logic                        armed;
        logic                        done;
        logic                        fail;
        logic [TAP_W:0]              size;
        logic [NPADS-1:0][DSK_W-1:0] dsk;
        logic [NPADS-1:0]            we;
    } state_t;

    state_t state_d, state_q;

    logic [NBITS-1:0][TAP_W-1:0] first_arr, last_arr;
    logic [NPADS-1:0][DSK_W-1:0] cur_arr, fix_val;
    logic [NPADS-1:0]            fix_touch;
    logic [TAP_W-1:0]            lane_first, lane_last;
    logic [TAP_W:0]              lane_size;
    edge_flags_t                 flags;
    run_kind_t                   kind;
    logic                        armed_now;

    assign first_arr = bit_first_i;
    assign last_arr  = bit_last_i;
    assign cur_arr   = pad_cur_i;

    win_extent #(.NBITS(NBITS), .TAP_W(TAP_W)) i_extent (
        .first_i      (first_arr),
        .last_i       (last_arr),
        .lane_first_o (lane_first),
        .lane_last_o  (lane_last)
    );

    edge_classify #(.TAP_W(TAP_W), .LOW_LIMIT(LOW_LIMIT), .HIGH_LIMIT(HIGH_LIMIT)) i_classify (
        .lane_first_i (lane_first),
        .lane_last_i  (lane_last),
        .flags_o      (flags),
        .size_o       (lane_size)
    );

    pad_fix #(
        .NBITS(NBITS), .NPADS(NPADS), .DSK_W(DSK_W), .STEP(STEP),
        .HI_PAD_A(HI_PAD_A), .HI_PAD_B(HI_PAD_B), .BIT_PAD(BIT_PAD)
    ) i_fix (
        .cur_i   (cur_arr),
        .flags_i (flags),
        .val_o   (fix_val),
        .touch_o (fix_touch)
    );

    // Sort the request into one of the run kinds; re-arm counts in the same cycle.
    always_comb begin
        armed_now = state_q.armed || rearm_i;
        if (!start_i) begin
            kind = RUN_NONE;
        end else if (!armed_now) begin
            kind = RUN_SKIP;
        end else if (!(lock_rise_i && lock_fall_i)) begin
            kind = RUN_NOLOCK;
        end else begin
            kind = RUN_EVAL;
        end
    end

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        state_d.fail = 1'b0;
        state_d.we   = '0;
        if (rearm_i) state_d.armed = 1'b1;
        unique case (kind)
            RUN_SKIP: begin
                state_d.done = 1'b1;
                state_d.size = '0;
            end
            RUN_NOLOCK: begin
                state_d.done  = 1'b1;
                state_d.fail  = 1'b1;
                state_d.size  = '0;
                state_d.armed = 1'b0;
            end
            RUN_EVAL: begin
                state_d.done  = 1'b1;
                state_d.size  = lane_size;
                state_d.dsk   = fix_val;
                state_d.we    = fix_touch;
                state_d.armed = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.armed <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign done_o     = state_q.done;
    assign fail_o     = state_q.fail;
    assign win_size_o = state_q.size;
    assign pad_val_o  = state_q.dsk;
    assign pad_we_o   = state_q.we;

    assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    assert_no_stray_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    assert_flags_need_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o || (pad_we_o != '0)) |-> done_o);
    assert_fail_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (pad_we_o == '0) && (win_size_o == '0));
    assert_nolock_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && armed_now && !(lock_rise_i && lock_fall_i)) |=> fail_o);
    assert_size_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (win_size_o <= (TAP_W+1)'(1 << TAP_W)));
    assert_no_edge_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !flags.low && !flags.high) |=> (pad_we_o == '0));
    assert_skip_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !state_q.armed && !rearm_i) |=> (!fail_o && (pad_we_o == '0)));
    assert_used_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !rearm_i) |=> !state_q.armed);

endmodule

// File: tb/test_rd_edge_corrector.sv
`timescale 1ns/1ps
module test_rd_edge_corrector;

    localparam int NB = 8;
    localparam int NP = 6;
    localparam int MAP [NB] = '{0, 1, 2, 3, 4, 0, 1, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, rearm_i = 1'b0;
    logic lock_rise_i = 1'b1, lock_fall_i = 1'b1;
    logic [NB-1:0][4:0] first_v = '0, last_v = '0;
    logic [NP-1:0][4:0] cur_v = '0;
    logic done_o, fail_o;
    logic [5:0] win_size_o;
    logic [NP*5-1:0] pad_val_o;
    logic [NP-1:0] pad_we_o;
    logic [NP-1:0][4:0] val_arr;

    int checks = 0;
    int fails = 0;
    bit model_armed = 1'b1;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign val_arr = pad_val_o;

    rd_edge_corrector i_rd_edge_corrector (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rearm_i(rearm_i),
        .lock_rise_i(lock_rise_i), .lock_fall_i(lock_fall_i),
        .bit_first_i(first_v), .bit_last_i(last_v), .pad_cur_i(cur_v),
        .done_o(done_o), .fail_o(fail_o), .win_size_o(win_size_o),
        .pad_val_o(pad_val_o), .pad_we_o(pad_we_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One start, with the result predicted from the requirements.
    task automatic run(input bit rearm_now, input string tag);
        int smax, emin, exp_size;
        bit low, high, armed_use, locked;
        int exp_val [NP];
        bit exp_we [NP];
        armed_use = model_armed || rearm_now;
        locked = lock_rise_i && lock_fall_i;
        smax = 0;
        emin = 31;
        for (int b = 0; b < NB; b++) begin
            if (int'(first_v[b]) > smax) smax = int'(first_v[b]);
            if (int'(last_v[b]) < emin) emin = int'(last_v[b]);
        end
        low = (smax <= 1);
        high = (emin > 30);
        exp_size = (emin >= smax) ? emin - smax + 1 : 0;
        for (int p = 0; p < NP; p++) begin
            bit hit;
            int v;
            hit = 1'b0;
            for (int b = 0; b < NB; b++) if (MAP[b] == p) hit = 1'b1;
            v = int'(cur_v[p]);
            exp_we[p] = 1'b0;
            if (hit && low) begin
                v = (v + 10 > 31) ? 31 : v + 10;
                exp_we[p] = 1'b1;
            end
            if (high && (p == 4 || p == 5)) begin
                v = (v + 10) % 32;
                exp_we[p] = 1'b1;
            end
            exp_val[p] = v;
            if (!armed_use || !locked) exp_we[p] = 1'b0;
        end
        if (!armed_use || !locked) exp_size = 0;
        @(negedge clk);
        start_i = 1'b1;
        rearm_i = rearm_now;
        @(negedge clk);
        start_i = 1'b0;
        rearm_i = 1'b0;
        if (armed_use) model_armed = 1'b0;
        chk(done_o === 1'b1, {tag, " done"}, int'(done_o), 1);
        chk(fail_o === (armed_use && !locked), {tag, " fail"}, int'(fail_o), int'(armed_use && !locked));
        chk(int'(win_size_o) == exp_size, {tag, " size"}, int'(win_size_o), exp_size);
        for (int p = 0; p < NP; p++) begin
            chk(pad_we_o[p] === exp_we[p], {tag, " we"}, int'(pad_we_o[p]), int'(exp_we[p]));
            if (exp_we[p]) chk(int'(val_arr[p]) == exp_val[p], {tag, " val"}, int'(val_arr[p]), exp_val[p]);
        end
        @(negedge clk);
        chk(done_o === 1'b0 && pad_we_o === '0, {tag, " pulse R2"}, int'(done_o), 0);
    endtask

    task automatic load(input int s [NB], input int e [NB], input int c [NP]);
        for (int b = 0; b < NB; b++) begin
            first_v[b] = 5'(s[b]);
            last_v[b] = 5'(e[b]);
        end
        for (int p = 0; p < NP; p++) cur_v[p] = 5'(c[p]);
    endtask

    task automatic t_reset();
        chk(done_o === 1'b0 && fail_o === 1'b0, "R1 done/fail", int'(done_o), 0);
        chk(pad_we_o === '0 && win_size_o === '0, "R1 we/size", int'(pad_we_o), 0);
    endtask

    task automatic t_low_edge();
        load('{0, 1, 0, 1, 0, 0, 1, 0}, '{20, 22, 25, 21, 24, 28, 23, 26}, '{25, 3, 31, 0, 21, 9});
        run(1'b0, "R5 low edge R4");
    endtask

    task automatic t_once();
        load('{0, 0, 0, 0, 0, 0, 0, 0}, '{31, 31, 31, 31, 31, 31, 31, 31}, '{1, 2, 3, 4, 5, 6});
        run(1'b0, "R9 skip");
    endtask

    task automatic t_no_edge();
        @(negedge clk);
        rearm_i = 1'b1;
        @(negedge clk);
        rearm_i = 1'b0;
        model_armed = 1'b1;
        load('{3, 8, 5, 7, 2, 6, 4, 8}, '{22, 25, 30, 24, 23, 29, 27, 26}, '{4, 5, 6, 7, 8, 9});
        run(1'b0, "R8 no edge R10");
    endtask

    task automatic t_high_edge();
        load('{5, 10, 7, 3, 9, 6, 8, 4}, '{31, 31, 31, 31, 31, 31, 31, 31}, '{11, 12, 13, 14, 25, 7});
        run(1'b1, "R6 high edge R10");
    endtask

    task automatic t_both();
        load('{1, 0, 0, 1, 0, 0, 0, 1}, '{31, 31, 31, 31, 31, 31, 31, 31}, '{22, 0, 15, 30, 28, 2});
        run(1'b1, "R7 both");
    endtask

    task automatic t_inverted();
        load('{20, 3, 4, 5, 6, 7, 8, 9}, '{10, 25, 26, 27, 28, 29, 30, 30}, '{1, 1, 1, 1, 1, 1});
        run(1'b1, "R4 inverted");
    endtask

    task automatic t_nolock();
        load('{0, 0, 0, 0, 0, 0, 0, 0}, '{31, 31, 31, 31, 31, 31, 31, 31}, '{5, 5, 5, 5, 5, 5});
        lock_fall_i = 1'b0;
        run(1'b1, "R3 nolock");
        lock_fall_i = 1'b1;
        run(1'b0, "R3 used up R9");
        lock_rise_i = 1'b0;
        run(1'b1, "R3 rise nolock");
        lock_rise_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_edge();
        t_once();
        t_no_edge();
        t_high_edge();
        t_both();
        t_inverted();
        t_nolock();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule